// File: doc/BRIEF.md
# Parallel Bus Word/Long-Word Slave Interface

This block connects a processor's generic parallel bus to a 32-bit internal register and memory space. The processor frames each access with an active-low strobe and an active-low chip enable, gives a read/write level, an address and data, and waits for an active-low acknowledge. The bus controls may change at any time relative to the system clock. In the default build they pass through a two-flop synchronizer per signal. A build parameter can remove the synchronizer for a processor that runs on the same clock. Each control then goes through an edge detector that gives one-cycle pulses on its falling and rising edges.

A controller state machine has five states. ST_IDLE waits for an access to start. ST_RD_REQ issues an internal read. ST_RD_WAIT waits for the read data. ST_RD_HOLD presents the data on the bus before the acknowledge. ST_ACK holds the acknowledge until the access ends. The transitions are:
- start-write: ST_IDLE to ST_ACK.
- start-read: ST_IDLE to ST_RD_REQ.
- start-upper-read: ST_IDLE to ST_RD_HOLD.
- ST_RD_REQ to ST_RD_WAIT, ST_RD_WAIT to ST_RD_HOLD and ST_RD_HOLD to ST_ACK: one clock each.
- release: ST_ACK to ST_IDLE.
- abort: any read state to ST_IDLE when the strobe ends early.

A static width input selects a 32-bit bus or a 16-bit bus. In 16-bit mode, two bus accesses make up one 32-bit long word: the lower half first, then the upper half. A write capture pair has a separate load enable for each half. A read capture register holds the long word, and an upper-half select chooses which half goes out on the bus. As a result, the internal space always sees a single 32-bit transfer.

Top module: `pbus_wlw_if`

## Requirements
- R1: While reset is asserted and after it is released, `dtack_n` is 1, `req_valid` is 0 and `dq_oe` is 0.
- R2: An access starts when `stb_n` falls while `ce_n` is low. `dtack_n` for a write falls on the third rising clock edge after the strobe falls, for a strobe change just after an edge. This is 2 or 3 clocks, depending on where the strobe falls between edges.
- R3: A 32-bit write gives exactly one single-cycle `req_valid` pulse, on the same edge on which `dtack_n` falls. The pulse carries `req_write`=1, `req_wdata` equal to `dq_in` and `req_addr` equal to `addr[6:0]`.
- R4: In 16-bit mode, the first write captures `dq_in[15:0]` as the lower half and makes no request. The second write captures `dq_in[15:0]` as the upper half and makes one request with `{second, first}` as its data. `dq_in[31:16]` is ignored in this mode.
- R5: A 32-bit read gives one `req_valid` pulse with `req_write`=0. The internal data must be valid in the clock after that pulse. The captured word is driven on all 32 bits of `dq_out`, and `dtack_n` falls on the sixth edge after the strobe (5 or 6 clocks).
- R6: For every read, `dq_oe` is 1 and `dq_out` holds the final value for at least one clock before `dtack_n` falls.
- R7: In 16-bit mode, the first read fetches the long word and returns bits 15:0 on `dq_out[15:0]` with zeros above. The second read makes no request, returns bits 31:16 of the captured word, and gets `dtack_n` on the fourth edge (3 or 4 clocks).
- R8: `dtack_n` returns to 1 on the second edge after the strobe rises, for a strobe change just after an edge (1 or 2 clocks).
- R9: Address bit 7 (the MSB) selects the space: 1 selects memory (`mem_rdata`, `req_mem`=1) and 0 selects registers (`reg_rdata`, `req_mem`=0).
- R10: A strobe while `ce_n` is high is ignored: `dtack_n` stays 1 and no request is made.
- R11: An access also starts when `ce_n` falls while `stb_n` is already low, with the same timing as R2, counted from the falling `ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | Static bus width: 1 = 32-bit, 0 = 16-bit |
| stb_n | input | 1 | Active-low access strobe |
| ce_n | input | 1 | Active-low chip enable |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 8 | Bus address; MSB selects memory space |
| dq_in | input | 32 | Bus write data |
| dq_out | output | 32 | Bus read data |
| dq_oe | output | 1 | Read data valid, enable for the pad driver |
| dtack_n | output | 1 | Active-low acknowledge |
| req_valid | output | 1 | One-cycle internal transfer request |
| req_write | output | 1 | Request direction: 1 = write |
| req_mem | output | 1 | Request targets memory space |
| req_addr | output | 7 | Internal address |
| req_wdata | output | 32 | Assembled 32-bit write word |
| reg_rdata | input | 32 | Register space read data, valid the clock after the request |
| mem_rdata | input | 32 | Memory space read data, valid the clock after the request |

## Verification
In the bench, inputs change and outputs are sampled 2 ns after each rising edge, so the count of edges from a stimulus to a result is exact. A write acknowledge and its request are due 3 edges after the strobe falls. A full-word read or lower-half read is due at 6 edges, and an upper-half read at 4 edges. The read data must already be on `dq_out` one edge earlier, and the acknowledge is released 2 edges after the strobe rises. For every access, the bench records the step at which `req_valid` and a low `dtack_n` first appear and compares them with these counts. It also checks that the acknowledge is still high one step before it is due.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    // Controller states of the bus slave
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_RD_HOLD = 3'd3,
        ST_ACK     = 3'd4
    } bus_state_e;

    // Bit positions of the bus controls in the edge detector vector
    localparam int SIG_STB = 0;
    localparam int SIG_CE  = 1;
    localparam int NUM_CTL = 2;

endpackage

// File: rtl/pbus_edge.sv
module pbus_edge #(
    parameter int N       = 2,
    parameter bit ASYNC   = 1'b1,
    parameter int STAGES  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);

    logic [N-1:0] cur;
    logic [N-1:0] prev_q;

    if (ASYNC) begin : g_async
        // Synchronizer chain, one flop per stage per control
        logic [N-1:0] stg_q [STAGES];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) begin
                    stg_q[i] <= '1;
                end
            end else begin
                stg_q[0] <= raw;
                for (int i = 1; i < STAGES; i++) begin
                    stg_q[i] <= stg_q[i-1];
                end
            end
        end

        assign cur = stg_q[STAGES-1];
    end else begin : g_sync
        assign cur = raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= cur;
        end
    end

    assign lvl  = cur;
    assign fall = prev_q & ~cur;
    assign rise = ~prev_q & cur;

    // R2: an edge pulse never lasts more than one clock
    p_fall_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((fall & $past(fall)) == '0));

endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
    import pbus_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          start,
    input  logic          stop,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    output logic          wen_ls,
    output logic          wen_ms,
    output logic          rd_load,
    output logic          rd_msw,
    output logic          req_valid,
    output logic          req_write,
    output logic          req_mem,
    output logic [AW-2:0] req_addr,
    output logic          dtack_q,
    output logic          oe
);

    bus_state_e state_q;
    bus_state_e state_d;

    logic          half_q;      // 1: next 16-bit access is the upper half
    logic          req_q;
    logic          req_write_q;
    logic          req_mem_q;
    logic [AW-2:0] req_addr_q;
    logic          rd_msw_q;
    logic          dtack_r;
    logic          oe_q;

    logic accept;
    logic narrow_ms;
    logic issue_wr;
    logic issue_rd;

    assign accept    = start && (state_q == ST_IDLE);
    assign narrow_ms = !wide_mode && half_q;
    assign issue_wr  = accept && !rd_wr && (wide_mode || half_q);
    assign issue_rd  = accept && rd_wr && !narrow_ms;

    // Capture enables act on the same edge that accepts the access
    assign wen_ls  = accept && !rd_wr && (wide_mode || !half_q);
    assign wen_ms  = accept && !rd_wr && (wide_mode || half_q);
    assign rd_load = (state_q == ST_RD_WAIT) && !stop;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!rd_wr) begin
                        state_d = ST_ACK;
                    end else if (narrow_ms) begin
                        state_d = ST_RD_HOLD;
                    end else begin
                        state_d = ST_RD_REQ;
                    end
                end
            end
            ST_RD_REQ:  state_d = stop ? ST_IDLE : ST_RD_WAIT;
            ST_RD_WAIT: state_d = stop ? ST_IDLE : ST_RD_HOLD;
            ST_RD_HOLD: state_d = stop ? ST_IDLE : ST_ACK;
            ST_ACK:     state_d = stop ? ST_IDLE : ST_ACK;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q      <= 1'b0;
            req_q       <= 1'b0;
            req_write_q <= 1'b0;
            req_mem_q   <= 1'b0;
            req_addr_q  <= '0;
            rd_msw_q    <= 1'b0;
            dtack_r     <= 1'b1;
            oe_q        <= 1'b0;
        end else begin
            req_q   <= issue_wr || issue_rd;
            dtack_r <= (state_d != ST_ACK);
            oe_q    <= (state_d == ST_RD_HOLD) || ((state_d == ST_ACK) && oe_q);
            if (accept) begin
                req_write_q <= !rd_wr;
                req_mem_q   <= addr[AW-1];
                req_addr_q  <= addr[AW-2:0];
                rd_msw_q    <= narrow_ms;
                half_q      <= wide_mode ? 1'b0 : !half_q;
            end
        end
    end

    assign rd_msw    = rd_msw_q;
    assign req_valid = req_q;
    assign req_write = req_write_q;
    assign req_mem   = req_mem_q;
    assign req_addr  = req_addr_q;
    assign dtack_q   = dtack_r;
    assign oe        = oe_q;

    // R3: a request is a single-cycle pulse
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R4: a 16-bit write request only follows the upper-half access
    p_narrow_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && req_write_q && !wide_mode) |-> !half_q);

    // R6: read data is enabled at least one clock before acknowledge
    p_oe_before_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dtack_r) && !req_write_q) |-> $past(oe_q));

    // R8: no acknowledge while idle
    p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> dtack_r);

endmodule

// File: rtl/pbus_capture.sv
module pbus_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic [DW-1:0] dq_in,
    input  logic          wen_ls,
    input  logic          wen_ms,
    input  logic          rd_load,
    input  logic          rd_sel_mem,
    input  logic          rd_msw,
    input  logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] dq_out
);

    localparam int HW = DW / 2;

    logic [HW-1:0] wcap_ls_q;
    logic [HW-1:0] wcap_ms_q;
    logic [HW-1:0] ms_in;
    logic [DW-1:0] rcap_q;
    logic [DW-1:0] rd_src;

    // Upper write half: upper bus lines in 32-bit mode, lower lines in 16-bit mode
    assign ms_in  = wide_mode ? dq_in[DW-1:HW] : dq_in[HW-1:0];
    // Read capture source: memory or register space
    assign rd_src = rd_sel_mem ? mem_rdata : reg_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcap_ls_q <= '0;
            wcap_ms_q <= '0;
            rcap_q    <= '0;
        end else begin
            if (wen_ls) begin
                wcap_ls_q <= dq_in[HW-1:0];
            end
            if (wen_ms) begin
                wcap_ms_q <= ms_in;
            end
            if (rd_load) begin
                rcap_q <= rd_src;
            end
        end
    end

    assign wdata = {wcap_ms_q, wcap_ls_q};

    always_comb begin
        if (wide_mode) begin
            dq_out = rcap_q;
        end else if (rd_msw) begin
            dq_out = {{HW{1'b0}}, rcap_q[DW-1:HW]};
        end else begin
            dq_out = {{HW{1'b0}}, rcap_q[HW-1:0]};
        end
    end

    // R5: the upper-half select stays fixed in 32-bit mode
    p_rsel_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && rd_load) |-> !rd_msw);

    // R7: an upper-half read never reloads the capture register
    p_ms_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_msw |-> !rd_load);

endmodule

// File: rtl/pbus_wlw_if.sv
module pbus_wlw_if
    import pbus_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 8,
    parameter bit ASYNC_BUS   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          stb_n,
    input  logic          ce_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          dtack_n,
    output logic          req_valid,
    output logic          req_write,
    output logic          req_mem,
    output logic [AW-2:0] req_addr,
    output logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] mem_rdata
);

    logic [NUM_CTL-1:0] ctl_raw;
    logic [NUM_CTL-1:0] ctl_lvl;
    logic [NUM_CTL-1:0] ctl_fall;
    logic [NUM_CTL-1:0] ctl_rise;

    logic start;
    logic stop;
    logic wen_ls;
    logic wen_ms;
    logic rd_load;
    logic rd_msw;
    logic dtack_q;

    assign ctl_raw[SIG_STB] = stb_n;
    assign ctl_raw[SIG_CE]  = ce_n;

    pbus_edge #(
        .N      (NUM_CTL),
        .ASYNC  (ASYNC_BUS),
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (ctl_raw),
        .lvl   (ctl_lvl),
        .fall  (ctl_fall),
        .rise  (ctl_rise)
    );

    // Access begins when the second of strobe and enable goes active
    assign start = (ctl_fall[SIG_STB] && !ctl_lvl[SIG_CE]) ||
                   (ctl_fall[SIG_CE]  && !ctl_lvl[SIG_STB]);
    assign stop  = ctl_rise[SIG_STB] || ctl_rise[SIG_CE];

    pbus_ctrl #(
        .AW (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .start     (start),
        .stop      (stop),
        .rd_wr     (rd_wr),
        .addr      (addr),
        .wen_ls    (wen_ls),
        .wen_ms    (wen_ms),
        .rd_load   (rd_load),
        .rd_msw    (rd_msw),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_addr  (req_addr),
        .dtack_q   (dtack_q),
        .oe        (dq_oe)
    );

    pbus_capture #(
        .DW (DW)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_mode  (wide_mode),
        .dq_in      (dq_in),
        .wen_ls     (wen_ls),
        .wen_ms     (wen_ms),
        .rd_load    (rd_load),
        .rd_sel_mem (req_mem),
        .rd_msw     (rd_msw),
        .reg_rdata  (reg_rdata),
        .mem_rdata  (mem_rdata),
        .wdata      (req_wdata),
        .dq_out     (dq_out)
    );

    // Release acknowledge as soon as the end of the strobe is detected
    assign dtack_n = dtack_q || stop;

endmodule

// File: tb/test_pbus_wlw_if.sv
`timescale 1ns/100ps
module test_pbus_wlw_if;

    typedef struct packed {
        logic        wide;
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        exp_req;
        logic [31:0] exp_word;
        logic [3:0]  exp_ack;
        logic [1:0]  half;     // 0 full word, 1 lower half, 2 upper half
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'h85, 32'hA5A5_1234, 1'b1, 32'hA5A5_1234, 4'd3, 2'd0},
        '{1'b1, 1'b0, 8'h12, 32'h0BAD_F00D, 1'b1, 32'h0BAD_F00D, 4'd3, 2'd0},
        '{1'b1, 1'b1, 8'h83, 32'h0,         1'b1, 32'h0,         4'd6, 2'd0},
        '{1'b1, 1'b1, 8'h07, 32'h0,         1'b1, 32'h0,         4'd6, 2'd0},
        '{1'b0, 1'b0, 8'h90, 32'h1111_BEEF, 1'b0, 32'h0,         4'd3, 2'd0},
        '{1'b0, 1'b0, 8'h91, 32'h2222_CAFE, 1'b1, 32'hCAFE_BEEF, 4'd3, 2'd0},
        '{1'b0, 1'b1, 8'hA0, 32'h0,         1'b1, 32'h0,         4'd6, 2'd1},
        '{1'b0, 1'b1, 8'hA0, 32'h0,         1'b0, 32'h0,         4'd4, 2'd2}
    };

    logic        clk;
    logic        rst_n;
    logic        wide_mode;
    logic        stb_n;
    logic        ce_n;
    logic        rd_wr;
    logic [7:0]  addr;
    logic [31:0] dq_in;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic        dtack_n;
    logic        req_valid;
    logic        req_write;
    logic        req_mem;
    logic [6:0]  req_addr;
    logic [31:0] req_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] mem_rdata;

    int total = 0;
    int bad   = 0;

    pbus_wlw_if i_pbus_wlw_if (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .stb_n     (stb_n),
        .ce_n      (ce_n),
        .rd_wr     (rd_wr),
        .addr      (addr),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .dtack_n   (dtack_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .reg_rdata (reg_rdata),
        .mem_rdata (mem_rdata)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [31:0] memf(input logic [6:0] a);
        return {8'hA0, 1'b0, a, 8'h5C, 1'b1, a};
    endfunction

    function automatic logic [31:0] regf(input logic [6:0] a);
        return {8'h3E, 1'b0, a, 8'h71, 1'b0, a};
    endfunction

    // Internal space model: data valid the clock after a read request
    always @(posedge clk) begin
        if (req_valid && !req_write) begin
            mem_rdata <= memf(req_addr);
            reg_rdata <= regf(req_addr);
        end else begin
            mem_rdata <= 32'hDEAD_BEEF;
            reg_rdata <= 32'h0BAD_0BAD;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_access(input vec_t v);
        int          ack_at;
        int          req_at;
        int          req_cnt;
        logic        rq_wr;
        logic        rq_mem;
        logic [6:0]  rq_addr;
        logic [31:0] rq_data;
        logic [31:0] src;
        logic [31:0] exp_out;
        ack_at  = 0;
        req_at  = 0;
        req_cnt = 0;
        rq_wr   = 1'b0;
        rq_mem  = 1'b0;
        rq_addr = '0;
        rq_data = '0;
        src     = v.addr[7] ? memf(v.addr[6:0]) : regf(v.addr[6:0]);
        case (v.half)
            2'd1:    exp_out = {16'h0, src[15:0]};
            2'd2:    exp_out = {16'h0, src[31:16]};
            default: exp_out = src;
        endcase
        wide_mode = v.wide;
        rd_wr     = v.rd;
        addr      = v.addr;
        dq_in     = v.wdata;
        ce_n      = 1'b0;
        stb_n     = 1'b0;
        for (int s = 1; s <= 12 && ack_at == 0; s++) begin
            step();
            if (req_valid) begin
                req_cnt++;
                req_at  = s;
                rq_wr   = req_write;
                rq_mem  = req_mem;
                rq_addr = req_addr;
                rq_data = req_wdata;
            end
            if (v.rd && s == int'(v.exp_ack) - 1) begin
                // R6: data and enable settled one clock ahead of acknowledge
                chk("R6 dq_oe before ack", {31'b0, dq_oe}, 32'd1);
                chk("R6 dtack_n still high", {31'b0, dtack_n}, 32'd1);
                if (v.half == 2'd0)      chk("R5 full read data", dq_out, exp_out);
                else                     chk("R7 half read data", dq_out, exp_out);
                if (v.wide)              chk("R9 space select data", dq_out, exp_out);
            end
            if (!dtack_n) ack_at = s;
        end
        if (v.rd && v.half == 2'd0)      chk("R5 read ack edge", ack_at, 32'(v.exp_ack));
        else if (v.rd)                   chk("R7 half read ack edge", ack_at, 32'(v.exp_ack));
        else                             chk("R2 write ack edge", ack_at, 32'(v.exp_ack));
        // release
        stb_n = 1'b1;
        ce_n  = 1'b1;
        step();
        if (req_valid) req_cnt++;
        chk("R8 ack held one clock after release", {31'b0, dtack_n}, 32'd0);
        step();
        if (req_valid) req_cnt++;
        chk("R8 ack released", {31'b0, dtack_n}, 32'd1);
        step();
        if (req_valid) req_cnt++;
        step();
        if (!v.wide && !v.rd)            chk("R4 request count", req_cnt, {31'b0, v.exp_req});
        else if (v.half == 2'd2)         chk("R7 upper read makes no request", req_cnt, 32'd0);
        else                             chk("R3 request count", req_cnt, {31'b0, v.exp_req});
        if (v.exp_req) begin
            chk("R3 request edge", req_at, 32'd3);
            chk("R3 request direction", {31'b0, rq_wr}, {31'b0, !v.rd});
            chk("R9 request space", {31'b0, rq_mem}, {31'b0, v.addr[7]});
            chk("R3 request address", {25'b0, rq_addr}, {25'b0, v.addr[6:0]});
            if (!v.rd && !v.wide)        chk("R4 assembled word", rq_data, v.exp_word);
            else if (!v.rd)              chk("R3 write word", rq_data, v.exp_word);
        end
    endtask

    initial begin
        #50000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int errs;
        int ack_at;
        int req_cnt;
        logic [31:0] word;
        rst_n     = 1'b0;
        wide_mode = 1'b1;
        stb_n     = 1'b1;
        ce_n      = 1'b1;
        rd_wr     = 1'b0;
        addr      = '0;
        dq_in     = '0;
        step();
        step();
        // R1: reset state
        chk("R1 dtack_n in reset", {31'b0, dtack_n}, 32'd1);
        chk("R1 req_valid in reset", {31'b0, req_valid}, 32'd0);
        chk("R1 dq_oe in reset", {31'b0, dq_oe}, 32'd0);
        rst_n = 1'b1;
        step();
        step();
        chk("R1 idle after reset", {29'b0, dtack_n, req_valid, dq_oe}, 32'h4);

        for (int i = 0; i < NVEC; i++) begin
            run_access(VECS[i]);
        end

        // R10: strobe with chip enable high is ignored
        wide_mode = 1'b1;
        rd_wr     = 1'b0;
        addr      = 8'h81;
        dq_in     = 32'h1234_5678;
        ce_n      = 1'b1;
        stb_n     = 1'b0;
        errs      = 0;
        for (int s = 0; s < 8; s++) begin
            step();
            if (!dtack_n || req_valid) errs++;
        end
        stb_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            step();
            if (!dtack_n || req_valid) errs++;
        end
        chk("R10 ignored strobe", errs, 32'd0);

        // R11: chip enable falling with strobe already low starts an access
        addr   = 8'h8F;
        dq_in  = 32'h600D_CAFE;
        stb_n  = 1'b0;
        step();
        step();
        step();
        step();
        ce_n    = 1'b0;
        ack_at  = 0;
        req_cnt = 0;
        word    = '0;
        for (int s = 1; s <= 8 && ack_at == 0; s++) begin
            step();
            if (req_valid) begin
                req_cnt++;
                word = req_wdata;
            end
            if (!dtack_n) ack_at = s;
        end
        chk("R11 ack edge after enable", ack_at, 32'd3);
        chk("R11 request count", req_cnt, 32'd1);
        chk("R11 write word", word, 32'h600D_CAFE);
        stb_n = 1'b1;
        ce_n  = 1'b1;
        step();
        step();
        chk("R8 release after enable access", {31'b0, dtack_n}, 32'd1);
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule